// File: doc/BRIEF.md
# Miss Frequency Estimator

The block keeps a rough count of how many times each block-aligned 32-bit address has missed in the main cache. Five banks of 8-bit counters each take their index from a different bit field of the address. Some fields overlap and they are not all the same width. An update port increments the five counters that an address selects. A query port reads the five counters that another address selects and returns the smallest of them. Taking the minimum limits the damage done when other addresses alias into the same counters.

Counters stop at their top value instead of wrapping. The block counts how many counters have just reached that value. When the count reaches a set limit, the block walks every counter index, one per cycle, and writes zero to it. While the walk runs, the block raises a busy flag and ignores both ports. The same walk also runs when the block leaves reset, so that every counter starts at zero.

Top module: `miss_freq_est`

## Requirements
- R1: Addresses are block aligned, and their lowest OFF_W bits (default 6) are zero. Each bank takes its index from its own address field, given as lowest bit and width. The defaults are: bank 0 uses bits [16:6], bank 1 uses [28:21], bank 2 uses [31:29], bank 3 uses [18:9] and bank 4 uses [24:19]. With LOW_W = 15, bank 0 covers [20:6].
- R2: An accepted update (`upd_valid` high and `busy` low at a clock edge) increments the selected counter in every bank by one.
- R3: An accepted query (`qry_valid` high and `busy` low at a clock edge) raises `res_valid` for exactly the next cycle. In that cycle, `res_freq` holds the minimum of the five selected counters.
- R4: A counter at 255 stays at 255 when it is incremented.
- R5: A saturation event is one increment that takes a counter from 254 to 255. Increments of a counter already at 255 are not events. Once the running total of events reaches SAT_LIMIT (default 8), `busy` rises right after that clock edge, and the total returns to zero.
- R6: A clear keeps `busy` high for exactly 2^W clock edges, where W is the widest bank index (2048 edges by default). After the clear, every counter reads zero.
- R7: While `busy` is high, updates change no counter, and queries produce no `res_valid`.
- R8: When an update and a query select the same counters in the same cycle, the query returns the values from before the increment.
- R9: During reset and right after it, `busy` is 1 and `res_valid` is 0. The walk that follows reset leaves every counter at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Increment the counters for `upd_addr` |
| upd_addr | input | 32 | Block-aligned address of a main-cache miss |
| qry_valid | input | 1 | Request an estimate for `qry_addr` |
| qry_addr | input | 32 | Block-aligned address to estimate |
| busy | output | 1 | Clear walk in progress; both ports are ignored |
| res_valid | output | 1 | `res_freq` is valid this cycle |
| res_freq | output | 8 | Estimated miss count (minimum of the five counters) |

## Verification
The hardest case to reach from the ports is the clear caused by saturation. The bench drives the same address for 255 cycles in a row, which saturates five counters together. It then sends one more update to that address to show that a counter held at 255 adds no events. A second address with entirely separate fields is then driven to 255 to cross the limit. To show that updates are ignored while busy, the bench sends an update on the last cycle of the reset walk. By that cycle the walk has already passed every index the update selects, so an applied update would survive and show up in a later query.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  localparam int ADDR_W    = 32;
  localparam int CNT_W     = 8;
  localparam int NUM_BANKS = 5;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef cnt_t [NUM_BANKS-1:0] cnt_vec_t;

  localparam cnt_t CNT_TOP = '1;

  // increment that sticks at the top value
  function automatic cnt_t sat_inc(cnt_t v);
    return (v == CNT_TOP) ? v : cnt_t'(v + 1'b1);
  endfunction

  // true when this increment lands exactly on the top value
  function automatic logic hits_top(cnt_t v);
    return v == cnt_t'(CNT_TOP - 1'b1);
  endfunction

  function automatic cnt_t min_of(cnt_vec_t v);
    cnt_t m;
    m = v[0];
    for (int i = 1; i < NUM_BANKS; i++)
      if (v[i] < m) m = v[i];
    return m;
  endfunction

  function automatic int widest(int a, int b, int c, int d, int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction
endpackage

// File: rtl/mfe_bank.sv
module mfe_bank
  import mfe_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] qry_idx,
  output cnt_t             qry_val,
  output logic             sat_hit
);
  localparam int DEPTH = 1 << IDX_W;

  cnt_t mem [DEPTH];
  cnt_t cur;

  assign cur     = mem[inc_idx];
  assign qry_val = mem[qry_idx];
  assign sat_hit = inc_en && !clr_en && hits_top(cur);

  always_ff @(posedge clk) begin
    if (clr_en)      mem[clr_idx] <= '0;
    else if (inc_en) mem[inc_idx] <= sat_inc(cur);
  end

  // R4
  hold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !clr_en && cur == CNT_TOP) |=> mem[$past(inc_idx)] == CNT_TOP);

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !clr_en && cur != CNT_TOP) |=> mem[$past(inc_idx)] == cnt_t'($past(cur) + 1'b1));
endmodule

// File: rtl/mfe_clear_ctl.sv
module mfe_clear_ctl #(
  parameter int SAT_LIMIT = 8,
  parameter int NB        = 5,
  parameter int CLR_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    sat_hits,
  output logic             clr_en,
  output logic [CLR_W-1:0] clr_idx,
  output logic             busy
);
  localparam int TOT_W = $clog2(SAT_LIMIT + NB + 1);
  localparam logic [CLR_W-1:0] LAST_IDX = '1;

  logic [TOT_W-1:0] total, total_nxt;
  logic             active;
  logic [CLR_W-1:0] idx;
  logic             clr_start;

  assign total_nxt = total + TOT_W'($countones(sat_hits));
  assign clr_start = !active && (total_nxt >= TOT_W'(SAT_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b1;
      idx    <= '0;
      total  <= '0;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (idx == LAST_IDX) active <= 1'b0;
    end else if (clr_start) begin
      active <= 1'b1;
      idx    <= '0;
      total  <= '0;
    end else begin
      total <= total_nxt;
    end
  end

  assign busy    = active;
  assign clr_en  = active;
  assign clr_idx = idx;

  // R5
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(total_nxt) >= TOT_W'(SAT_LIMIT));

  // R6
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idx != LAST_IDX) |=> (active && idx == $past(idx) + 1'b1));

  // R6
  walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idx == LAST_IDX) |=> !active);

  // R7
  quiet_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> sat_hits == '0);
endmodule

// File: rtl/miss_freq_est.sv
module miss_freq_est
  import mfe_pkg::*;
#(
  parameter int OFF_W     = 6,
  parameter int LOW_LSB   = 6,
  parameter int LOW_W     = 11,
  parameter int MID_LSB   = 21,
  parameter int MID_W     = 8,
  parameter int HIGH_LSB  = 29,
  parameter int HIGH_W    = 3,
  parameter int X1_LSB    = 9,
  parameter int X1_W      = 10,
  parameter int X2_LSB    = 19,
  parameter int X2_W      = 6,
  parameter int SAT_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              qry_valid,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              busy,
  output logic              res_valid,
  output logic [CNT_W-1:0]  res_freq
);
  localparam int F_LSB [NUM_BANKS] = '{LOW_LSB, MID_LSB, HIGH_LSB, X1_LSB, X2_LSB};
  localparam int F_W   [NUM_BANKS] = '{LOW_W, MID_W, HIGH_W, X1_W, X2_W};
  localparam int CLR_W = widest(LOW_W, MID_W, HIGH_W, X1_W, X2_W);

  logic                 upd_take, qry_take;
  logic                 clr_en;
  logic [CLR_W-1:0]     clr_idx;
  logic [NUM_BANKS-1:0] sat_hits;
  cnt_vec_t             rd_q;

  assign upd_take = upd_valid && !busy;
  assign qry_take = qry_valid && !busy;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W = F_W[b];
    localparam int L = F_LSB[b];
    logic [W-1:0] u_idx, q_idx;
    assign u_idx = upd_addr[L +: W];
    assign q_idx = qry_addr[L +: W];

    mfe_bank #(.IDX_W(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (upd_take),
      .inc_idx (u_idx),
      .clr_en  (clr_en),
      .clr_idx (clr_idx[W-1:0]),
      .qry_idx (q_idx),
      .qry_val (rd_q[b]),
      .sat_hit (sat_hits[b])
    );

    // R3
    min_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_freq <= $past(rd_q[b]));
  end

  mfe_clear_ctl #(
    .SAT_LIMIT (SAT_LIMIT),
    .NB        (NUM_BANKS),
    .CLR_W     (CLR_W)
  ) u_clear (
    .clk      (clk),
    .rst_n    (rst_n),
    .sat_hits (sat_hits),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_freq  <= '0;
    end else begin
      res_valid <= qry_take;
      if (qry_take) res_freq <= min_of(rd_q);
    end
  end

  // R3
  min_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_freq == $past(rd_q[0]) || res_freq == $past(rd_q[1]) ||
                   res_freq == $past(rd_q[2]) || res_freq == $past(rd_q[3]) ||
                   res_freq == $past(rd_q[4])));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !res_valid);

  // R1
  upd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_addr[OFF_W-1:0] == '0);

  // R1
  qry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |-> qry_addr[OFF_W-1:0] == '0);
endmodule

// File: tb/miss_freq_est_test.sv
module miss_freq_est_test;
  localparam int WALK = 1 << 11;
  localparam logic [31:0] A_AD = 32'h0000_0040;
  localparam logic [31:0] B_AD = 32'h0000_0080;
  localparam logic [31:0] C_AD = 32'hFFFF_FFC0;
  localparam logic [31:0] F_AD = 32'h2000_0040;

  // {is_query, address, expected}
  localparam logic [40:0] VEC [16] = '{
    {1'b0, A_AD, 8'd0}, {1'b1, A_AD, 8'd1}, {1'b1, 32'h0, 8'd0}, {1'b0, A_AD, 8'd0},
    {1'b1, A_AD, 8'd2}, {1'b1, B_AD, 8'd0}, {1'b0, B_AD, 8'd0}, {1'b1, B_AD, 8'd1},
    {1'b1, A_AD, 8'd2}, {1'b0, C_AD, 8'd0}, {1'b0, C_AD, 8'd0}, {1'b0, C_AD, 8'd0},
    {1'b1, C_AD, 8'd3}, {1'b1, 32'h100, 8'd0}, {1'b1, F_AD, 8'd0}, {1'b1, C_AD, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic        qry_valid = 1'b0;
  logic [31:0] qry_addr = '0;
  logic        busy, res_valid;
  logic [7:0]  res_freq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  miss_freq_est uut (
    .clk (clk), .rst_n (rst_n), .upd_valid (upd_valid), .upd_addr (upd_addr),
    .qry_valid (qry_valid), .qry_addr (qry_addr), .busy (busy),
    .res_valid (res_valid), .res_freq (res_freq)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic upd_n(logic [31:0] a, int n);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a;
    repeat (n) @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic qry(logic [31:0] a, int exp, string req);
    @(negedge clk);
    qry_valid = 1'b1; qry_addr = a;
    @(negedge clk);
    qry_valid = 1'b0;
    chk(req, int'(res_valid), 1);
    chk(req, int'(res_freq), exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R9 reset state, R6 walk length, R7 update and query during the walk
    do_reset();
    chk("R9 busy after reset", int'(busy), 1);
    chk("R9 res_valid after reset", int'(res_valid), 0);
    repeat (WALK - 1) @(negedge clk);
    chk("R6 still busy before last edge", int'(busy), 1);
    upd_valid = 1'b1; upd_addr = 32'h0;
    qry_valid = 1'b1; qry_addr = 32'h0;
    @(negedge clk);
    upd_valid = 1'b0; qry_valid = 1'b0;
    chk("R6 busy falls after walk", int'(busy), 0);
    chk("R7 query ignored while busy", int'(res_valid), 0);
    qry(32'h0, 0, "R7 update ignored while busy");

    // R1 R2 R3 vector table
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][40]) qry(VEC[i][39:8], int'(VEC[i][7:0]), "R3 table query");
      else            upd_n(VEC[i][39:8], 1);
    end

    // R8 update and query to the same address in one cycle
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = A_AD;
    qry_valid = 1'b1; qry_addr = A_AD;
    @(negedge clk);
    upd_valid = 1'b0; qry_valid = 1'b0;
    chk("R8 pre-increment value", int'(res_freq), 2);
    qry(A_AD, 3, "R8 increment applied");

    // R4 R5 R6 saturation and clear
    do_reset();
    wait_idle();
    upd_n(A_AD, 254);
    qry(A_AD, 254, "R2 long run");
    chk("R5 no clear below limit", int'(busy), 0);
    upd_n(A_AD, 1);
    qry(A_AD, 255, "R4 reaches top");
    upd_n(A_AD, 1);
    qry(A_AD, 255, "R4 holds at top");
    chk("R5 held top adds no event", int'(busy), 0);
    upd_n(C_AD, 254);
    chk("R5 no clear before events", int'(busy), 0);
    upd_n(C_AD, 1);
    chk("R5 busy after limit reached", int'(busy), 1);
    @(negedge clk);
    qry_valid = 1'b1; qry_addr = C_AD;
    @(negedge clk);
    qry_valid = 1'b0;
    chk("R7 no result while clearing", int'(res_valid), 0);
    wait_idle();
    qry(A_AD, 0, "R6 cleared first address");
    qry(C_AD, 0, "R6 cleared second address");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule